// File: doc/BRIEF.md
# Absent-Slave Shadow and DASP Drive Control

This block sits in a storage device that answers on the host's ATA cable as the master, and it decides whether the device should also answer for a slave drive that is not fitted. While the device is strapped as master and firmware has not yet committed the choice, a flag called shadow-enable tracks the resynchronized DASP pin level. A second device pulls DASP during its power-up, so the pin level shows whether a real slave exists. Once firmware sets the commit bit, the flag freezes and stops tracking the pin. Firmware should set the commit bit no earlier than 450 ms after a chip reset or a host reset. Emulating the slave's task-file registers belongs to logic outside this block.

The block also makes the enable for driving DASP. Three select bits gate this enable, one for each reset phase. The first covers the time while host reset is held. The second covers the time after host reset is released. The third covers the time after a software reset ends. Firmware reads and writes all of these bits through a single control byte on a simple register bus. The byte reads back continuously, and a write strobe with write data updates it.

Top module: `shadow_dasp_ctrl`

## Requirements
- R1: After chip reset (`rst_n` low), `rd_data` is 0x00, `shadow_en` is 0 and `dasp_drv_en` is 0.
- R2: Control byte bits 7, 4 and 3 always read 0, whatever value is written to them.
- R3: While `master_cfg` is 1 and the commit bit (bit 5) is 0, `shadow_en` (also read as bit 6) equals the level that `dasp_pin` had three clock edges earlier (two synchronizer stages plus the register).
- R4: While the commit bit is 1 and no write or host reset occurs, `shadow_en` holds its value whatever `dasp_pin` does.
- R5: A clock edge with `host_rst` high clears the commit bit (bit 5) and the software-reset select (bit 0). Select bits 2 and 1 keep their values. Only `rst_n` clears those two.
- R6: A write to bit 6 is ignored while `master_cfg` is 1 and the commit bit is 0. It takes effect when the commit bit is 1.
- R7: While `master_cfg` is 0, bit 6 is a plain read/write bit: it loads from `wr_data[6]` on a write, holds otherwise, and ignores `dasp_pin`.
- R8: While `host_rst` is high and select bit 2 is 1, `dasp_drv_en` is 1 in the same cycle. With select bit 2 at 0, host reset alone does not raise it.
- R9: If select bit 1 is 1 on the edge where `host_rst` is first seen low after being high, `dasp_drv_en` is 1 from that edge on. It is held until a rising `host_rst` or `soft_rst` is seen, or until the edge after the one that writes select bit 1 to 0.
- R10: If the software-reset select (bit 0) is 1 on the edge where `soft_rst` is first seen low after being high, with `host_rst` low, `dasp_drv_en` is 1 from that edge on. It is held until a reset rise or until the edge after bit 0 is written to 0.
- R11: The control byte maps bit 6 to shadow-enable, bit 5 to commit, bit 2 to the host-reset-active select, bit 1 to the after-host-reset select and bit 0 to the after-software-reset select. Writing bits 5, 2, 1 and 0 reads them back on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Chip reset, active low, asynchronous |
| host_rst | input | 1 | Host reset level, active high, synchronous to clk |
| soft_rst | input | 1 | Software reset level, active high, synchronous to clk |
| master_cfg | input | 1 | Strap: 1 when the device is configured as master |
| dasp_pin | input | 1 | Raw DASP pin level, asynchronous |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte write data |
| rd_data | output | 8 | Control byte read value |
| shadow_en | output | 1 | Emulate-absent-slave flag |
| dasp_drv_en | output | 1 | Enable for driving DASP |

## Verification
The hardest states to reach from the ports are the ones where several reset phases overlap. One case is a software reset that rises while the after-host-reset enable is held. Another is a host reset that clears the software-reset select while a post-software-reset enable is pending. A third is a commit-bit write that lands on the same edge as a pin change. A directed sequence walks the clean orderings one at a time. A long seeded random run then produces short, independent pulses on both reset lines together with random writes, strap flips and pin toggles. A cycle-level bench model, built from the requirements, predicts all three outputs in every cycle.

// File: rtl/shadow_dasp_pkg.sv
package shadow_dasp_pkg;
    localparam int DATA_W   = 8;
    localparam int BIT_SHD  = 6;
    localparam int BIT_CMT  = 5;
    localparam int BIT_HOLD = 2;
    localparam int BIT_POST = 1;
    localparam int BIT_SOFT = 0;

    typedef struct packed {
        logic shadow;
        logic commit;
        logic sel_hold;
        logic sel_post;
        logic sel_soft;
    } ctl_t;

    typedef struct packed {
        logic hrst_prev;
        logic srst_prev;
        logic post_host;
        logic post_soft;
    } phase_t;
endpackage

// File: rtl/shadow_dasp_sync.sv
module shadow_dasp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/shadow_dasp_regs.sv
module shadow_dasp_regs
    import shadow_dasp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rst,
    input  logic              master_cfg,
    input  logic              pin_s,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output ctl_t              ctl_o
);
    ctl_t c_d, c_q;
    logic unused_rsvd;

    assign unused_rsvd = ^{wr_data[7], wr_data[4], wr_data[3]};

    always_comb begin
        c_d = c_q;
        if (wr_en) begin
            c_d.commit   = wr_data[BIT_CMT];
            c_d.sel_hold = wr_data[BIT_HOLD];
            c_d.sel_post = wr_data[BIT_POST];
            c_d.sel_soft = wr_data[BIT_SOFT];
        end
        if (host_rst) begin
            c_d.commit   = 1'b0;
            c_d.sel_soft = 1'b0;
        end
        if (master_cfg && !c_q.commit)
            c_d.shadow = pin_s;
        else if (wr_en)
            c_d.shadow = wr_data[BIT_SHD];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign ctl_o = c_q;
endmodule

// File: rtl/shadow_dasp_phase.sv
module shadow_dasp_phase
    import shadow_dasp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic host_rst,
    input  logic soft_rst,
    input  logic sel_hold,
    input  logic sel_post,
    input  logic sel_soft,
    output logic drv_en
);
    phase_t p_d, p_q;
    logic h_rise, h_fall, s_rise, s_fall;

    always_comb begin
        h_rise = host_rst  & ~p_q.hrst_prev;
        h_fall = ~host_rst &  p_q.hrst_prev;
        s_rise = soft_rst  & ~p_q.srst_prev;
        s_fall = ~soft_rst &  p_q.srst_prev;

        p_d           = p_q;
        p_d.hrst_prev = host_rst;
        p_d.srst_prev = soft_rst;

        if (h_fall && sel_post)
            p_d.post_host = 1'b1;
        else if (h_rise || s_rise || !sel_post)
            p_d.post_host = 1'b0;

        if (s_fall && sel_soft && !host_rst)
            p_d.post_soft = 1'b1;
        else if (h_rise || s_rise || host_rst || !sel_soft)
            p_d.post_soft = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign drv_en = (host_rst & sel_hold) | p_q.post_host | p_q.post_soft;
endmodule

// File: rtl/shadow_dasp_ctrl.sv
module shadow_dasp_ctrl
    import shadow_dasp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rst,
    input  logic              soft_rst,
    input  logic              master_cfg,
    input  logic              dasp_pin,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              shadow_en,
    output logic              dasp_drv_en
);
    logic pin_s;
    ctl_t ctl;

    shadow_dasp_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (dasp_pin),
        .dout (pin_s)
    );

    shadow_dasp_regs regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_rst  (host_rst),
        .master_cfg(master_cfg),
        .pin_s     (pin_s),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ctl_o     (ctl)
    );

    shadow_dasp_phase phase_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .host_rst(host_rst),
        .soft_rst(soft_rst),
        .sel_hold(ctl.sel_hold),
        .sel_post(ctl.sel_post),
        .sel_soft(ctl.sel_soft),
        .drv_en  (dasp_drv_en)
    );

    always_comb begin
        rd_data           = '0;
        rd_data[BIT_SHD]  = ctl.shadow;
        rd_data[BIT_CMT]  = ctl.commit;
        rd_data[BIT_HOLD] = ctl.sel_hold;
        rd_data[BIT_POST] = ctl.sel_post;
        rd_data[BIT_SOFT] = ctl.sel_soft;
    end

    assign shadow_en = ctl.shadow;
endmodule

// File: rtl/shadow_dasp_chk.sv
module shadow_dasp_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_rst,
    input logic       soft_rst,
    input logic       master_cfg,
    input logic       wr_en,
    input logic [7:0] rd_data,
    input logic       shadow_en,
    input logic       dasp_drv_en
);
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] == 1'b0) && (rd_data[4] == 1'b0) && (rd_data[3] == 1'b0));

    p_commit_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[5] && !wr_en && !host_rst) |=> $stable(shadow_en));

    p_host_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_rst |=> (!rd_data[5] && !rd_data[0]));

    p_plain_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_cfg && !wr_en) |=> $stable(shadow_en));

    p_hold_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rst && rd_data[2]) |-> dasp_drv_en);

    p_after_host_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(host_rst) && rd_data[1]) |=> dasp_drv_en);

    p_after_soft_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(soft_rst) && rd_data[0] && !host_rst) |=> dasp_drv_en);

    p_mirror_view_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[6] == shadow_en);
endmodule

bind shadow_dasp_ctrl shadow_dasp_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_rst   (host_rst),
    .soft_rst   (soft_rst),
    .master_cfg (master_cfg),
    .wr_en      (wr_en),
    .rd_data    (rd_data),
    .shadow_en  (shadow_en),
    .dasp_drv_en(dasp_drv_en)
);

// File: tb/shadow_dasp_ctrl_tb_top.sv
module shadow_dasp_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_rst = 1'b0, soft_rst = 1'b0, master_cfg = 1'b0, dasp_pin = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       shadow_en, dasp_drv_en;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    shadow_dasp_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .host_rst(host_rst), .soft_rst(soft_rst),
        .master_cfg(master_cfg), .dasp_pin(dasp_pin), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .shadow_en(shadow_en),
        .dasp_drv_en(dasp_drv_en)
    );

    // Cycle model built from the requirements
    logic m_s1, m_s2, m_shd, m_cmt, m_hold, m_post, m_soft;
    logic m_hprev, m_sprev, m_ph, m_ps;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {m_s1, m_s2, m_shd, m_cmt, m_hold, m_post, m_soft} <= '0;
            {m_hprev, m_sprev, m_ph, m_ps} <= '0;
        end else begin
            m_s1 <= dasp_pin;
            m_s2 <= m_s1;
            m_hprev <= host_rst;
            m_sprev <= soft_rst;
            m_cmt  <= host_rst ? 1'b0 : (wr_en ? wr_data[5] : m_cmt);
            m_soft <= host_rst ? 1'b0 : (wr_en ? wr_data[0] : m_soft);
            if (wr_en) begin
                m_hold <= wr_data[2];
                m_post <= wr_data[1];
            end
            if (master_cfg && !m_cmt) m_shd <= m_s2;
            else if (wr_en)           m_shd <= wr_data[6];
            if (!host_rst && m_hprev && m_post) m_ph <= 1'b1;
            else if ((host_rst && !m_hprev) || (soft_rst && !m_sprev) || !m_post) m_ph <= 1'b0;
            if (!soft_rst && m_sprev && m_soft && !host_rst) m_ps <= 1'b1;
            else if (host_rst || (soft_rst && !m_sprev) || !m_soft) m_ps <= 1'b0;
        end
    end

    function automatic logic [7:0] exp_rd();
        return {1'b0, m_shd, m_cmt, 2'b00, m_hold, m_post, m_soft};
    endfunction

    function automatic logic exp_drv();
        return (host_rst & m_hold) | m_ph | m_ps;
    endfunction

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        chk("R1 rd", rd_data, 8'h00);
        chk("R1 shadow", {7'd0, shadow_en}, 8'h00);
        chk("R1 drv", {7'd0, dasp_drv_en}, 8'h00);
        rst_n = 1'b1;
        tick(2);

        // not master: plain bit, reserved bits zero, bit map
        master_cfg = 1'b0; dasp_pin = 1'b1;
        wr(8'hFF);
        chk("R2 R11 R7 write all ones", rd_data, 8'h67);
        tick(4);
        chk("R7 pin ignored", {7'd0, shadow_en}, 8'h01);
        wr(8'h18);
        chk("R2 R7 reserved only", rd_data, 8'h00);
        tick(4);
        chk("R7 shadow stays low", {7'd0, shadow_en}, 8'h00);

        // master mirror
        master_cfg = 1'b1;
        tick(4);
        chk("R3 mirror high", {7'd0, shadow_en}, 8'h01);
        dasp_pin = 1'b0;
        tick(2);
        chk("R3 not yet through", {7'd0, shadow_en}, 8'h01);
        tick(1);
        chk("R3 three edges", {7'd0, shadow_en}, 8'h00);
        wr(8'h40);
        chk("R6 write ignored uncommitted", {7'd0, shadow_en}, 8'h00);

        // commit freeze
        dasp_pin = 1'b1;
        tick(4);
        wr(8'h20);
        chk("R11 commit set", rd_data, 8'h60);
        dasp_pin = 1'b0;
        tick(6);
        chk("R4 frozen", {7'd0, shadow_en}, 8'h01);
        wr(8'h20);
        chk("R6 write effective committed", {7'd0, shadow_en}, 8'h00);
        wr(8'h60);
        chk("R6 write back high", {7'd0, shadow_en}, 8'h01);

        // host reset phases
        wr(8'h27);
        host_rst = 1'b1;
        tick();
        chk("R8 drive during host reset", {7'd0, dasp_drv_en}, 8'h01);
        tick(2);
        host_rst = 1'b0;
        tick();
        chk("R5 bits after host reset", rd_data & 8'h27, 8'h06);
        chk("R9 drive after host reset", {7'd0, dasp_drv_en}, 8'h01);
        tick(5);
        chk("R9 held", {7'd0, dasp_drv_en}, 8'h01);
        soft_rst = 1'b1;
        tick();
        chk("R9 cleared by reset rise", {7'd0, dasp_drv_en}, 8'h00);
        soft_rst = 1'b0;
        tick();
        chk("R10 no select no drive", {7'd0, dasp_drv_en}, 8'h00);

        // sel1 clear drops enable
        wr(8'h02);
        host_rst = 1'b1; tick();
        chk("R8 no hold select", {7'd0, dasp_drv_en}, 8'h00);
        host_rst = 1'b0; tick();
        chk("R9 after host again", {7'd0, dasp_drv_en}, 8'h01);
        wr(8'h00);
        tick();
        chk("R9 cleared by select write", {7'd0, dasp_drv_en}, 8'h00);

        // software reset phase
        wr(8'h01);
        soft_rst = 1'b1; tick(2);
        chk("R10 not during soft reset", {7'd0, dasp_drv_en}, 8'h00);
        soft_rst = 1'b0; tick();
        chk("R10 drive after soft reset", {7'd0, dasp_drv_en}, 8'h01);
        tick(3);
        chk("R10 held", {7'd0, dasp_drv_en}, 8'h01);
        wr(8'h00);
        tick();
        chk("R10 cleared by select write", {7'd0, dasp_drv_en}, 8'h00);

        // random phase against the model
        void'($urandom(32'h5EED_0042));
        for (int c = 0; c < 4000; c++) begin
            master_cfg = ($urandom % 16) != 0 ? master_cfg : ~master_cfg;
            dasp_pin   = ($urandom % 4) == 0 ? ~dasp_pin : dasp_pin;
            wr_en      = ($urandom % 6) == 0;
            wr_data    = 8'($urandom);
            host_rst   = ($urandom % 12) == 0 ? ~host_rst : host_rst;
            soft_rst   = ($urandom % 10) == 0 ? ~soft_rst : soft_rst;
            tick();
            chk("R11 model rd", rd_data, exp_rd());
            chk("R3 model shadow", {7'd0, shadow_en}, {7'd0, m_shd});
            chk("R9 model drive", {7'd0, dasp_drv_en}, {7'd0, exp_drv()});
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule